// File: doc/BRIEF.md
# Peripheral Bus Clock Divider with Keyed Ratio Update

The block derives a peripheral bus timing strobe from the system clock. A free-running phase counter spans one output period of `field + 1` system cycles. On the last cycle of each period, while the output is enabled, `pb_tick` pulses for one cycle. Logic on the peripheral bus uses this pulse as its clock enable.

Software changes the divide ratio and the enable bit through one control write. That write is accepted only under two conditions: the correct unlock key was written just before, and the ready flag is high. An accepted write drops `div_ready` and parks the new setting. The setting is committed on the last cycle of the period then running, so the old period always completes in full. Ready then returns high and the readback shows the committed value.

The sequencer has three states:
- `ST_LOCKED` is the reset state; control writes are ignored here.
- `ST_OPEN` is entered from `ST_LOCKED` by a key write carrying the unlock value.
- `ST_APPLY` is entered from `ST_OPEN` by a control write.

Transitions back:
- A wrong key write in `ST_OPEN` returns to `ST_LOCKED`.
- `ST_APPLY` returns to `ST_LOCKED` on the period-end cycle, which is where the commit happens.

Top module: `pbclk_divider`

## Requirements
- R1: After reset the ratio readback `stat_div` is 1 (a ratio of 2), `stat_en` is 0, `div_ready` is 1 and `pb_tick` stays low.
- R2: The ratio field encodes ratio minus one. With the output enabled, `pb_tick` is high for one cycle in every `stat_div + 1` cycles.
- R3: Field value 0 gives a tick on every cycle, and field value 127 gives one tick per 128 cycles.
- R4: A control write made without a prior key write of the unlock value (default 16'hC35A) is ignored: readback, enable and ready are unchanged.
- R5: A key write with any other value withdraws an earlier unlock, so a following control write is ignored.
- R6: One unlock authorises exactly one control write; a second control write without a new key is ignored.
- R7: After an accepted control write, `div_ready` is low from the next cycle until the commit. Key and control writes made while it is low are ignored.
- R8: The new setting is committed on the final cycle of the running period. On that cycle the old tick, if enabled, still appears. The wait lasts at most one old period. In the next cycle `div_ready` is high and `stat_div` shows the new field. The first new tick comes `field` cycles after that.
- R9: The enable bit is committed together with the ratio. While it is 0, `pb_tick` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_wr | input | 1 | Key write strobe |
| key_val | input | 16 | Key value written |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_en | input | 1 | Requested output enable |
| ctrl_div | input | 7 | Requested ratio minus one |
| pb_tick | output | 1 | One-cycle strobe at each output period end |
| stat_en | output | 1 | Committed enable |
| stat_div | output | 7 | Committed ratio minus one |
| div_ready | output | 1 | High when a new setting may be written |

## Verification
The hardest condition to reach is a write arriving during the pending window, because that window lasts at most one old period. The bench therefore first programs the longest ratio of 128. It then issues a key and a second control write while ready is still low, and confirms two things: the first setting is the one committed, and the key from the pending window leaves nothing unlocked. The commit point is checked by recording the tick seen in the last not-ready cycle, and by counting the cycles from the ready rise to the first new tick.

// File: rtl/pbclk_pkg.sv
package pbclk_pkg;
    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_OPEN   = 2'd1,
        ST_APPLY  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/pbclk_phase.sv
// Free-running phase counter: one output period is div_i + 1 cycles.
module pbclk_phase #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             period_end_o
);
    logic [DIV_W-1:0] cnt;

    assign period_end_o = (cnt == div_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (period_end_o) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Counter only ever steps by one or wraps to zero: no shortened period.
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> (cnt == $past(cnt) + 1'b1)); // R8
endmodule

// File: rtl/pbclk_seq.sv
// Unlock / apply sequencer holding the pending and committed settings.
module pbclk_seq
    import pbclk_pkg::*;
#(
    parameter int               DIV_W      = 7,
    parameter int               KEY_W      = 16,
    parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hC35A,
    parameter logic [DIV_W-1:0] RESET_DIV  = 7'd1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    input  logic             ctrl_wr,
    input  logic             ctrl_en,
    input  logic [DIV_W-1:0] ctrl_div,
    input  logic             period_end,
    output logic [DIV_W-1:0] cur_div,
    output logic             cur_en,
    output logic             ready
);
    seq_state_t       state, nxt;
    logic [DIV_W-1:0] pend_div;
    logic             pend_en;
    logic             key_ok;

    assign key_ok = (key_val == UNLOCK_KEY);
    assign ready  = (state != ST_APPLY);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_LOCKED: if (key_wr && key_ok) nxt = ST_OPEN;
            ST_OPEN: begin
                if (ctrl_wr)                nxt = ST_APPLY;
                else if (key_wr && !key_ok) nxt = ST_LOCKED;
            end
            ST_APPLY:  if (period_end) nxt = ST_LOCKED;
            default:   nxt = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOCKED;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_div <= RESET_DIV;
            pend_en  <= 1'b0;
            cur_div  <= RESET_DIV;
            cur_en   <= 1'b0;
        end else begin
            if (state == ST_OPEN && ctrl_wr) begin
                pend_div <= ctrl_div;
                pend_en  <= ctrl_en;
            end
            if (state == ST_APPLY && period_end) begin
                cur_div <= pend_div;
                cur_en  <= pend_en;
            end
        end
    end

    AST_DIV_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_div) |-> $past(period_end)); // R8
    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(ctrl_wr)); // R7
    AST_READY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(period_end)); // R8
endmodule

// File: rtl/pbclk_divider.sv
module pbclk_divider #(
    parameter int               DIV_W      = 7,
    parameter int               KEY_W      = 16,
    parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hC35A,
    parameter logic [DIV_W-1:0] RESET_DIV  = 7'd1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    input  logic             ctrl_wr,
    input  logic             ctrl_en,
    input  logic [DIV_W-1:0] ctrl_div,
    output logic             pb_tick,
    output logic             stat_en,
    output logic [DIV_W-1:0] stat_div,
    output logic             div_ready
);
    logic period_end;

    pbclk_seq #(
        .DIV_W(DIV_W), .KEY_W(KEY_W),
        .UNLOCK_KEY(UNLOCK_KEY), .RESET_DIV(RESET_DIV)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .key_wr(key_wr), .key_val(key_val),
        .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en), .ctrl_div(ctrl_div),
        .period_end(period_end),
        .cur_div(stat_div), .cur_en(stat_en), .ready(div_ready)
    );

    pbclk_phase #(.DIV_W(DIV_W)) u_phase (
        .clk(clk), .rst_n(rst_n),
        .div_i(stat_div),
        .period_end_o(period_end)
    );

    assign pb_tick = period_end & stat_en;

    AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (div_ready && $past(div_ready)) |-> $stable(stat_div)); // R4
endmodule

// File: tb/sim_pbclk_divider.sv
module sim_pbclk_divider;
    localparam int DW = 7;
    localparam int KW = 16;
    localparam logic [KW-1:0] KEY = 16'hC35A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic key_wr = 1'b0;
    logic [KW-1:0] key_val = '0;
    logic ctrl_wr = 1'b0;
    logic ctrl_en = 1'b0;
    logic [DW-1:0] ctrl_div = '0;
    logic pb_tick, stat_en, div_ready;
    logic [DW-1:0] stat_div;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;
    int exp_div = 1;
    bit exp_en = 1'b0;

    always #10 clk = ~clk;

    pbclk_divider u0 (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_val(key_val),
        .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en), .ctrl_div(ctrl_div),
        .pb_tick(pb_tick), .stat_en(stat_en), .stat_div(stat_div),
        .div_ready(div_ready)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put_key(logic [KW-1:0] k);
        @(negedge clk); key_wr = 1'b1; key_val = k;
        @(negedge clk); key_wr = 1'b0;
    endtask

    task automatic put_ctrl(bit en, int dv);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_en = en; ctrl_div = DW'(dv);
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    // Settings must stay put with ready high for n cycles.
    task automatic hold_check(int n, string req);
        bit ok = 1'b1;
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!div_ready || stat_div != DW'(exp_div) || stat_en != exp_en) begin
                ok = 1'b0; bad = int'(stat_div);
            end
        end
        chk(ok, req, ok ? exp_div : bad, exp_div);
    endtask

    task automatic measure_period(int exp, string req);
        int n = 0;
        int w = 0;
        @(negedge clk);
        while (!pb_tick && w < 400) begin @(negedge clk); w++; end
        do begin @(negedge clk); n++; end while (!pb_tick && n < 400);
        chk(n == exp, req, n, exp);
    endtask

    task automatic apply_ok(bit en, int dv, string req);
        bit prev;
        int lows = 1;
        int k = 0;
        put_key(KEY);
        put_ctrl(en, dv);
        chk(div_ready == 1'b0, "R7 ready low after write", int'(div_ready), 0);
        prev = pb_tick;
        @(negedge clk);
        while (!div_ready && lows < 400) begin
            prev = pb_tick; lows++; @(negedge clk);
        end
        chk(prev == exp_en, "R8 old tick on commit cycle", int'(prev), int'(exp_en));
        chk(lows <= exp_div + 1, "R8 wait within one old period", lows, exp_div + 1);
        chk(stat_div == DW'(dv), req, int'(stat_div), dv);
        chk(stat_en == en, "R9 enable committed", int'(stat_en), int'(en));
        exp_div = dv; exp_en = en;
        if (en) begin
            while (!pb_tick && k < 400) begin @(negedge clk); k++; end
            chk(k == dv, "R8 first new tick", k, dv);
        end
    endtask

    task automatic t_reset();
        bit any = 1'b0;
        chk(stat_div == 7'd1, "R1 reset ratio", int'(stat_div), 1);
        chk(stat_en == 1'b0 && div_ready == 1'b1, "R1 reset flags",
            int'({stat_en, div_ready}), 1);
        for (int i = 0; i < 12; i++) begin @(negedge clk); any |= pb_tick; end
        chk(!any, "R1 no tick after reset", int'(any), 0);
    endtask

    task automatic t_locked();
        put_ctrl(1'b1, 5);
        hold_check(10, "R4 write without key ignored");
    endtask

    task automatic t_busy();
        bit seen_low;
        put_key(KEY);
        put_ctrl(1'b1, 9);
        seen_low = !div_ready;
        put_key(KEY);
        put_ctrl(1'b1, 20);
        chk(seen_low && !div_ready, "R7 still pending", int'(div_ready), 0);
        while (!div_ready) @(negedge clk);
        chk(stat_div == 7'd9, "R7 write while busy ignored", int'(stat_div), 9);
        exp_div = 9; exp_en = 1'b1;
        put_ctrl(1'b1, 30);
        hold_check(8, "R7 key while busy did not unlock");
    endtask

    task automatic t_one_shot();
        apply_ok(1'b1, 2, "R6 first write accepted");
        put_ctrl(1'b1, 4);
        hold_check(8, "R6 second write ignored");
    endtask

    task automatic t_wrong_key();
        put_key(KEY);
        put_key(16'h1234);
        put_ctrl(1'b1, 6);
        hold_check(8, "R5 wrong key relocks");
    endtask

    task automatic t_disable();
        bit any = 1'b0;
        apply_ok(1'b0, 2, "R9 disable committed");
        for (int i = 0; i < 20; i++) begin @(negedge clk); any |= pb_tick; end
        chk(!any, "R9 no tick when disabled", int'(any), 0);
        apply_ok(1'b1, 3, "R9 re-enable");
        measure_period(4, "R9 period after re-enable");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_locked();
        apply_ok(1'b1, 3, "R2 ratio readback 3");
        measure_period(4, "R2 period of 4");
        apply_ok(1'b1, 0, "R3 ratio readback 0");
        measure_period(1, "R3 tick every cycle");
        apply_ok(1'b1, 127, "R3 ratio readback 127");
        measure_period(128, "R3 period of 128");
        t_busy();
        t_one_shot();
        t_wrong_key();
        t_disable();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule